// File: doc/BRIEF.md
# Operand-Waiting Issue Stations

This block holds one waiting instruction per execution-unit class (integer ALU, load, store and two floating-point units) between dispatch and execution. A dispatched instruction brings its opcode, the reorder-buffer number that names its result, and two source operands. Each operand arrives in one of three states: already in the register file, already produced and parked in the reorder buffer, or still in flight. In the first two cases the value is stored at once. In the third case the producer's reorder-buffer number is stored and the operand waits.

The block watches a single result bus that carries one tag and one value per cycle. Any waiting operand whose stored tag equals the bus tag takes the bus value and becomes ready. This includes an operand being written by a dispatch in the same cycle. An instruction with both operands ready is offered to its unit. The station is freed when the unit accepts it, not when the result later comes back, because results are named by reorder-buffer numbers and never by station numbers. A flush empties every station.

Dispatch uses valid/ready. `disp_ready` reflects whether the station for the addressed unit class can take an instruction. A beat with `disp_valid` high and `disp_ready` low is ignored, and the sender holds it until ready. Each unit has its own issue valid/ready pair. Once raised, an offer and its payload hold until the unit accepts it or a flush removes it. The result bus has no back-pressure.

Top module: `opwait_station_bank`

## Requirements
- R1: After reset no station is occupied: every `iss_valid` bit is 0 and `disp_ready` is 1 for every unit code 0 to 4.
- R2: Unit codes are 0 ALU, 1 load, 2 store, 3 first FP unit, and 4 second FP unit. `disp_ready` is 0 while the addressed station is occupied. An accepted dispatch stores `disp_op` and `disp_dest`, which appear on that unit's `iss_op` and `iss_dest`. A refused beat leaves the occupied station's contents unchanged.
- R3: A source tag of 0 means the operand is taken from `disp_src_rf_val` and is ready.
- R4: A nonzero source tag with `disp_src_rob_rdy` set means the operand is taken from `disp_src_rob_val` and is ready.
- R5: A nonzero source tag with `disp_src_rob_rdy` clear is stored as pending. The instruction is not offered while any operand is pending.
- R6: When `bus_valid` is high and `bus_tag` equals a pending source tag, that operand takes `bus_value` at the clock edge. The instruction is offered from the next cycle if no operand is still pending.
- R7: The bus wakes nothing when `bus_valid` is low or when its tag matches no pending tag.
- R8: If a dispatch stores a pending tag equal to the tag on the result bus in that same cycle, the operand is captured from the bus and is ready.
- R9: `iss_valid[u]` is high only for an occupied station with both operands ready. While it is not accepted, it and its payload stay unchanged.
- R10: When `iss_valid[u]` and `iss_ready[u]` are both high at an edge, the station is free from the next cycle and `disp_ready` for that unit returns to 1.
- R11: `flush` empties every station at the clock edge, so pending tags no longer wake. `disp_ready` is 0 while `flush` is high, so a dispatch in that cycle is dropped.
- R12: Stations are independent: a dispatch or wake for one unit leaves the others unchanged. Unit codes 5 and above are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all stations |
| disp_valid | input | 1 | Dispatch beat present |
| disp_ready | output | 1 | Addressed station can accept |
| disp_unit | input | 3 | Unit class code |
| disp_op | input | OP_W | Opcode |
| disp_dest | input | TAG_W | Reorder-buffer number of the result |
| disp_src_tag | input | 2 x TAG_W | Producer tag per source, 0 = in register file |
| disp_src_rob_rdy | input | 2 | Producer value already in reorder buffer |
| disp_src_rf_val | input | 2 x DATA_W | Register-file value per source |
| disp_src_rob_val | input | 2 x DATA_W | Reorder-buffer value per source |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Result bus tag |
| bus_value | input | DATA_W | Result bus value |
| iss_valid | output | NUM_RS | Offer per unit |
| iss_ready | input | NUM_RS | Unit accepts its offer |
| iss_op | output | NUM_RS x OP_W | Opcode per unit |
| iss_dest | output | NUM_RS x TAG_W | Result tag per unit |
| iss_v1 | output | NUM_RS x DATA_W | First operand per unit |
| iss_v2 | output | NUM_RS x DATA_W | Second operand per unit |

## Verification
The case that is hardest to reach from the ports is a result broadcast that lands in the same cycle as the dispatch of its consumer. It slips past both the reorder-buffer path and the ordinary wake-up path. The bench reaches it by driving the bus with a tag before the dispatch edge and dispatching an operand that names that tag with the reorder-buffer flag clear. A second hard case is a refused dispatch to an occupied station. It is made visible by later waking the original instruction and checking that its opcode and tag survived.

// File: rtl/opwait_pkg.sv
package opwait_pkg;
  localparam int unsigned UNIT_CLASSES = 5;
  localparam int unsigned SRC_PER_OP   = 2;

  typedef enum logic [2:0] {
    UC_ALU   = 3'd0,
    UC_LOAD  = 3'd1,
    UC_STORE = 3'd2,
    UC_FPA   = 3'd3,
    UC_FPB   = 3'd4
  } unit_class_e;
endpackage

// File: rtl/opwait_src_resolve.sv
module opwait_src_resolve #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic [TAG_W-1:0]  src_tag,
  input  logic              rob_rdy,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] rob_val,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_val
);
  // priority: register file, reorder buffer, same-cycle bus, else wait
  always_comb begin
    res_tag = '0;
    res_val = '0;
    if (src_tag == '0) begin
      res_val = rf_val;
    end else if (rob_rdy) begin
      res_val = rob_val;
    end else if (bus_valid && (bus_tag == src_tag)) begin
      res_val = bus_value;
    end else begin
      res_tag = src_tag;
    end
  end
endmodule

// File: rtl/opwait_station.sv
module opwait_station #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                alloc,
  input  logic [OP_W-1:0]     alloc_op,
  input  logic [TAG_W-1:0]    alloc_dest,
  input  logic [1:0][TAG_W-1:0]  alloc_tag,
  input  logic [1:0][DATA_W-1:0] alloc_val,
  input  logic                bus_valid,
  input  logic [TAG_W-1:0]    bus_tag,
  input  logic [DATA_W-1:0]   bus_value,
  input  logic                grant,
  output logic                occupied,
  output logic                offer,
  output logic [OP_W-1:0]     op_q,
  output logic [TAG_W-1:0]    dest_q,
  output logic [DATA_W-1:0]   v1_q,
  output logic [DATA_W-1:0]   v2_q
);
  logic [1:0][TAG_W-1:0]  wait_tag;
  logic [1:0][DATA_W-1:0] opnd;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occupied <= 1'b0;
      op_q     <= '0;
      dest_q   <= '0;
      wait_tag <= '0;
      opnd     <= '0;
    end else if (alloc) begin
      occupied <= 1'b1;
      op_q     <= alloc_op;
      dest_q   <= alloc_dest;
      wait_tag <= alloc_tag;
      opnd     <= alloc_val;
    end else begin
      if (offer && grant) occupied <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        if (occupied && bus_valid && (wait_tag[s] != '0) && (bus_tag == wait_tag[s])) begin
          wait_tag[s] <= '0;
          opnd[s]     <= bus_value;
        end
      end
    end
  end

  assign offer = occupied && (wait_tag[0] == '0) && (wait_tag[1] == '0);
  assign v1_q  = opnd[0];
  assign v2_q  = opnd[1];

  // R9: an unaccepted offer keeps its payload
  p_offer_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (offer && !grant && !flush) |=> (offer && $stable(op_q) && $stable(dest_q) && $stable(v1_q) && $stable(v2_q)));

  // R10: acceptance frees the station
  p_free_on_grant_r10: assert property (@(posedge clk) disable iff (rst)
    (offer && grant && !flush) |=> !occupied);

  // R11: flush empties the station
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> !occupied);

  generate
    for (genvar s = 0; s < 2; s++) begin : g_wake_chk
      // R6: matching bus result is captured
      p_bus_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (occupied && !flush && !alloc && bus_valid && (wait_tag[s] != '0) && (bus_tag == wait_tag[s]))
        |=> ((wait_tag[s] == '0) && (opnd[s] == $past(bus_value))));
    end
  endgenerate
endmodule

// File: rtl/opwait_station_bank.sv
module opwait_station_bank
  import opwait_pkg::*;
#(
  parameter int unsigned NUM_RS = UNIT_CLASSES,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 4,
  localparam int unsigned UNIT_W = $clog2(NUM_RS + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           disp_valid,
  output logic                           disp_ready,
  input  logic [UNIT_W-1:0]              disp_unit,
  input  logic [OP_W-1:0]                disp_op,
  input  logic [TAG_W-1:0]               disp_dest,
  input  logic [1:0][TAG_W-1:0]          disp_src_tag,
  input  logic [1:0]                     disp_src_rob_rdy,
  input  logic [1:0][DATA_W-1:0]         disp_src_rf_val,
  input  logic [1:0][DATA_W-1:0]         disp_src_rob_val,
  input  logic                           bus_valid,
  input  logic [TAG_W-1:0]               bus_tag,
  input  logic [DATA_W-1:0]              bus_value,
  output logic [NUM_RS-1:0]              iss_valid,
  input  logic [NUM_RS-1:0]              iss_ready,
  output logic [NUM_RS-1:0][OP_W-1:0]    iss_op,
  output logic [NUM_RS-1:0][TAG_W-1:0]   iss_dest,
  output logic [NUM_RS-1:0][DATA_W-1:0]  iss_v1,
  output logic [NUM_RS-1:0][DATA_W-1:0]  iss_v2
);
  logic [1:0][TAG_W-1:0]  rslv_tag;
  logic [1:0][DATA_W-1:0] rslv_val;
  logic [NUM_RS-1:0]      occ;
  logic [NUM_RS-1:0]      alloc;
  logic                   sel_occ;

  generate
    for (genvar s = 0; s < SRC_PER_OP; s++) begin : g_src
      opwait_src_resolve #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_rslv (
        .src_tag   (disp_src_tag[s]),
        .rob_rdy   (disp_src_rob_rdy[s]),
        .rf_val    (disp_src_rf_val[s]),
        .rob_val   (disp_src_rob_val[s]),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_value (bus_value),
        .res_tag   (rslv_tag[s]),
        .res_val   (rslv_val[s])
      );
    end
  endgenerate

  // out-of-range unit codes look permanently occupied
  always_comb begin
    sel_occ = 1'b1;
    for (int u = 0; u < NUM_RS; u++) begin
      if (disp_unit == UNIT_W'(u)) sel_occ = occ[u];
    end
  end

  assign disp_ready = !flush && !sel_occ;

  generate
    for (genvar u = 0; u < NUM_RS; u++) begin : g_rs
      assign alloc[u] = disp_valid && disp_ready && (disp_unit == UNIT_W'(u));

      opwait_station #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_station (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .alloc      (alloc[u]),
        .alloc_op   (disp_op),
        .alloc_dest (disp_dest),
        .alloc_tag  (rslv_tag),
        .alloc_val  (rslv_val),
        .bus_valid  (bus_valid),
        .bus_tag    (bus_tag),
        .bus_value  (bus_value),
        .grant      (iss_ready[u]),
        .occupied   (occ[u]),
        .offer      (iss_valid[u]),
        .op_q       (iss_op[u]),
        .dest_q     (iss_dest[u]),
        .v1_q       (iss_v1[u]),
        .v2_q       (iss_v2[u])
      );
    end
  endgenerate

  // R12: unknown unit codes are never accepted
  p_bad_unit_refused_r12: assert property (@(posedge clk) disable iff (rst)
    (disp_unit >= UNIT_W'(NUM_RS)) |-> !disp_ready);
endmodule

// File: tb/opwait_station_bank_tb.sv
module opwait_station_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic disp_valid = 1'b0;
  logic disp_ready;
  logic [2:0] disp_unit = '0;
  logic [3:0] disp_op = '0;
  logic [3:0] disp_dest = '0;
  logic [1:0][3:0] disp_src_tag = '0;
  logic [1:0] disp_src_rob_rdy = '0;
  logic [1:0][31:0] disp_src_rf_val = '0;
  logic [1:0][31:0] disp_src_rob_val = '0;
  logic bus_valid = 1'b0;
  logic [3:0] bus_tag = '0;
  logic [31:0] bus_value = '0;
  logic [N-1:0] iss_valid;
  logic [N-1:0] iss_ready = '0;
  logic [N-1:0][3:0] iss_op;
  logic [N-1:0][3:0] iss_dest;
  logic [N-1:0][31:0] iss_v1;
  logic [N-1:0][31:0] iss_v2;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opwait_station_bank dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_unit(disp_unit),
    .disp_op(disp_op), .disp_dest(disp_dest), .disp_src_tag(disp_src_tag),
    .disp_src_rob_rdy(disp_src_rob_rdy), .disp_src_rf_val(disp_src_rf_val),
    .disp_src_rob_val(disp_src_rob_val),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_dest(iss_dest), .iss_v1(iss_v1), .iss_v2(iss_v2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ready(input logic [2:0] u, input logic exp, input string req);
    @(negedge clk);
    disp_unit = u;
    #1;
    chk(req, 32'(disp_ready), 32'(exp));
  endtask

  task automatic dispatch(input logic [2:0] u, input logic [3:0] op, input logic [3:0] dest,
                          input logic [3:0] t0, input logic r0, input logic [31:0] f0, input logic [31:0] b0,
                          input logic [3:0] t1, input logic r1, input logic [31:0] f1, input logic [31:0] b1);
    @(negedge clk);
    disp_unit = u; disp_op = op; disp_dest = dest;
    disp_src_tag[0] = t0; disp_src_rob_rdy[0] = r0; disp_src_rf_val[0] = f0; disp_src_rob_val[0] = b0;
    disp_src_tag[1] = t1; disp_src_rob_rdy[1] = r1; disp_src_rf_val[1] = f1; disp_src_rob_val[1] = b1;
    disp_valid = 1'b1;
    @(posedge clk);
    #1;
    disp_valid = 1'b0;
  endtask

  task automatic bus(input logic [3:0] tag, input logic [31:0] val, input logic vld);
    @(negedge clk);
    bus_tag = tag; bus_value = val; bus_valid = vld;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  task automatic issue(input int u);
    @(negedge clk);
    iss_ready[u] = 1'b1;
    @(posedge clk);
    #1;
    iss_ready[u] = 1'b0;
  endtask

  task automatic t_reset();
    for (int u = 0; u < N; u++) chk("R1 idle offer", 32'(iss_valid[u]), 0);
    for (int u = 0; u < N; u++) chk_ready(3'(u), 1'b1, "R1 ready after reset");
    chk_ready(3'd5, 1'b0, "R12 unit 5 refused");
    chk_ready(3'd7, 1'b0, "R12 unit 7 refused");
  endtask

  task automatic t_ready_sources();
    dispatch(3'd0, 4'h3, 4'd2, 4'd0, 1'b0, 32'h11, 32'hEE, 4'd3, 1'b1, 32'hDD, 32'h22);
    chk("R3 R4 offer", 32'(iss_valid[0]), 1);
    chk("R3 rf value", iss_v1[0], 32'h11);
    chk("R4 rob value", iss_v2[0], 32'h22);
    chk("R2 op", 32'(iss_op[0]), 3);
    chk("R2 dest", 32'(iss_dest[0]), 2);
    chk_ready(3'd0, 1'b0, "R2 busy stalls");
    @(posedge clk); #1;
    chk("R9 offer held", 32'(iss_valid[0]), 1);
    chk("R9 value held", iss_v1[0], 32'h11);
    issue(0);
    chk("R10 freed", 32'(iss_valid[0]), 0);
    chk_ready(3'd0, 1'b1, "R10 ready again");
  endtask

  task automatic t_wake();
    dispatch(3'd1, 4'h5, 4'd4, 4'd5, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0, 32'h33, 32'h0);
    chk("R5 pending not offered", 32'(iss_valid[1]), 0);
    bus(4'd6, 32'h66, 1'b1);
    chk("R7 other tag", 32'(iss_valid[1]), 0);
    bus(4'd5, 32'h55, 1'b0);
    chk("R7 bus invalid", 32'(iss_valid[1]), 0);
    bus(4'd5, 32'h55, 1'b1);
    chk("R6 woken", 32'(iss_valid[1]), 1);
    chk("R6 bus value", iss_v1[1], 32'h55);
    chk("R3 second src", iss_v2[1], 32'h33);
    issue(1);
  endtask

  task automatic t_stall();
    dispatch(3'd2, 4'h7, 4'd6, 4'd7, 1'b0, 32'h0, 32'h0, 4'd8, 1'b0, 32'h0, 32'h0);
    chk_ready(3'd2, 1'b0, "R2 store busy");
    dispatch(3'd2, 4'h9, 4'd9, 4'd0, 1'b0, 32'h1, 32'h0, 4'd0, 1'b0, 32'h2, 32'h0);
    chk("R2 refused beat not offered", 32'(iss_valid[2]), 0);
    dispatch(3'd3, 4'h1, 4'd10, 4'd0, 1'b0, 32'h44, 32'h0, 4'd0, 1'b0, 32'h45, 32'h0);
    chk("R12 other unit accepted", 32'(iss_valid[3]), 1);
    chk("R12 store untouched", 32'(iss_valid[2]), 0);
    bus(4'd7, 32'h77, 1'b1);
    chk("R5 one src still pending", 32'(iss_valid[2]), 0);
    bus(4'd8, 32'h88, 1'b1);
    chk("R6 both woken", 32'(iss_valid[2]), 1);
    chk("R2 original op kept", 32'(iss_op[2]), 7);
    chk("R2 original dest kept", 32'(iss_dest[2]), 6);
    chk("R6 src1", iss_v1[2], 32'h77);
    chk("R6 src2", iss_v2[2], 32'h88);
    chk("R12 fp unaffected by bus", iss_v1[3], 32'h44);
    issue(2);
    issue(3);
  endtask

  task automatic t_forward();
    @(negedge clk);
    bus_tag = 4'd9; bus_value = 32'h99; bus_valid = 1'b1;
    dispatch(3'd4, 4'h2, 4'd11, 4'd9, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0, 32'h12, 32'h0);
    bus_valid = 1'b0;
    chk("R8 forwarded offer", 32'(iss_valid[4]), 1);
    chk("R8 forwarded value", iss_v1[4], 32'h99);
    issue(4);
  endtask

  task automatic t_flush();
    dispatch(3'd3, 4'h1, 4'd12, 4'd13, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0, 32'h1, 32'h0);
    @(negedge clk);
    flush = 1'b1;
    disp_unit = 3'd0; disp_src_tag = '0; disp_src_rob_rdy = '0; disp_valid = 1'b1;
    #1;
    chk("R11 ready low in flush", 32'(disp_ready), 0);
    @(posedge clk); #1;
    flush = 1'b0; disp_valid = 1'b0;
    chk("R11 dispatch dropped", 32'(iss_valid[0]), 0);
    chk_ready(3'd3, 1'b1, "R11 fp freed");
    bus(4'd13, 32'hAB, 1'b1);
    chk("R11 stale tag no wake", 32'(iss_valid[3]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_ready_sources();
    t_wake();
    t_stall();
    t_forward();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule